// File: doc/BRIEF.md
# Sixteen-Bit Carry-Select Adder with Add-One Upper Paths

This block adds two 16-bit operands and a carry-in, producing a 16-bit sum and a carry-out, all within one combinational path. The operand bits are cut into five slices that widen towards the most significant end: 2, 2, 3, 4 and 5 bits, covering bits 1:0, 3:2, 6:4, 10:7 and 15:11. The bottom slice is a plain ripple adder fed by the external carry-in.

Every upper slice first forms its sum with an assumed carry-in of zero. An incrementer one bit wider than the slice then takes that sum together with its carry and adds one. This gives the result the slice would have if a carry did arrive. A two-way selector, steered by the real carry coming up from the slice below, picks one of the two results. The chosen value supplies the slice's sum bits and the carry for the next slice up. The incrementer takes the place of a second ripple adder, which keeps the logic smaller.

There is no clock, no reset and no handshake. The outputs follow the inputs after the adder's propagation delay, and the block is meant to sit inside a registered datapath stage.

Top module: `bec_sqrt_csa`

## Requirements
- R1: For every input combination, {carry_out, sum} equals op_a + op_b + carry_in as a 17-bit unsigned value.
- R2: The lowest slice (bits 1:0) adds the external carry_in directly, so op_a=0x0003, op_b=0x0000, carry_in=1 gives sum 0x0004.
- R3: The add-one converter of a w-bit slice is w+1 bits wide. It inverts bit 0, and flips bit i when all lower bits are 1, so that its output is its input plus one modulo 2^(w+1). Applying a carry into a slice therefore yields that slice's zero-carry value plus one for every slice value.
- R4: When no carry enters a slice, its sum bits and outgoing carry are the plain ripple result of its two operand fields.
- R5: When a carry enters a slice whose zero-carry sum is all ones, the slice bits wrap to zero and the slice passes a carry upwards (for example 0x7FFF + 0x0001 = 0x8000).
- R6: carry_out is the carry selected by the top slice (bits 15:11); 0xFFFF + 0x0001 gives sum 0x0000 with carry_out 1.
- R7: A carry_in of 1 ripples through all five slices when both operands give all-ones propagate: 0xFFFF + 0x0000 + 1 gives sum 0 with carry_out 1.
- R8: Slice boundaries sit above bits 1, 3, 6 and 10. A carry generated in the top bit of one slice is taken by the next slice (for example 0x0040 + 0x0040 = 0x0080).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | 16 | First addend |
| op_b | input | 16 | Second addend |
| carry_in | input | 1 | Carry into bit 0 |
| sum | output | 16 | Sum bits 15:0 |
| carry_out | output | 1 | Carry out of bit 15 |

## Verification
The block holds no state, so a wrong internal value shows up at the ports in the same evaluation as the inputs that expose it. A faulty incrementer bit or an inverted selector corrupts only the sum bits of its own slice, unless it also corrupts that slice's carry. A wrong carry then spreads into the slices above, up to carry_out. For this reason the stimulus drives a carry into each slice while that slice's zero-carry value sweeps through every code, including the all-ones wrap.

// File: rtl/csa_pkg.sv
package csa_pkg;
  localparam int unsigned DATA_W     = 16;
  localparam int unsigned NUM_GROUPS = 5;
  // slice widths, least significant first
  localparam int unsigned SLICE_W [NUM_GROUPS] = '{2, 2, 3, 4, 5};

  function automatic int unsigned slice_lsb(input int unsigned idx);
    int unsigned acc;
    acc = 0;
    for (int unsigned k = 0; k < NUM_GROUPS; k++) begin
      if (k < idx) acc += SLICE_W[k];
    end
    return acc;
  endfunction
endpackage

// File: rtl/csa_ripple.sv
module csa_ripple #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  logic [W:0] chain;
  assign chain[0] = cin;

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic p;
    assign p          = a[i] ^ b[i];
    assign s[i]       = p ^ chain[i];
    assign chain[i+1] = (a[i] & b[i]) | (p & chain[i]);
  end

  assign co = chain[W];

  always_comb begin
    if (!$isunknown({a, b, cin}))
      assert_ripple_add_R4: assert ({co, s} == ((W+1)'(a) + (W+1)'(b) + (W+1)'(cin)))
        else $error("ripple slice result wrong");
  end
endmodule

// File: rtl/csa_excess_one.sv
module csa_excess_one #(
  parameter int unsigned W = 3
) (
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] all_ones;   // all_ones[i] = AND of din[i:0]

  assign all_ones[0] = din[0];
  assign dout[0]     = ~din[0];

  for (genvar i = 1; i < W; i++) begin : g_bit
    assign all_ones[i] = all_ones[i-1] & din[i];
    assign dout[i]     = din[i] ^ all_ones[i-1];
  end

  always_comb begin
    if (!$isunknown(din)) begin
      assert_plus_one_R3: assert (dout == W'(din + W'(1)))
        else $error("converter is not input plus one");
      if (&din)
        assert_wrap_zero_R5: assert (dout == '0)
          else $error("converter did not wrap to zero");
    end
  end
endmodule

// File: rtl/csa_select_slice.sv
module csa_select_slice #(
  parameter int unsigned W = 2
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         co
);
  localparam int unsigned XW = W + 1;

  logic [W-1:0]  zero_sum;
  logic          zero_co;
  logic [XW-1:0] one_res;

  csa_ripple #(.W(W)) u_rca (
    .a   (a),
    .b   (b),
    .cin (1'b0),
    .s   (zero_sum),
    .co  (zero_co)
  );

  csa_excess_one #(.W(XW)) u_inc (
    .din  ({zero_co, zero_sum}),
    .dout (one_res)
  );

  assign {co, s} = cin ? one_res : {zero_co, zero_sum};

  always_comb begin
    if (!$isunknown({a, b, cin}))
      assert_slice_sum_R5: assert ({co, s} == (XW'(a) + XW'(b) + XW'(cin)))
        else $error("selected slice result wrong");
  end
endmodule

// File: rtl/bec_sqrt_csa.sv
module bec_sqrt_csa (
  input  logic [15:0] op_a,
  input  logic [15:0] op_b,
  input  logic        carry_in,
  output logic [15:0] sum,
  output logic        carry_out
);
  localparam int unsigned DW = csa_pkg::DATA_W;
  localparam int unsigned NG = csa_pkg::NUM_GROUPS;

  logic [NG:0] slice_c;   // slice_c[g] is the carry into slice g
  assign slice_c[0] = carry_in;

  for (genvar g = 0; g < NG; g++) begin : g_slice
    localparam int unsigned LSB = csa_pkg::slice_lsb(g);
    localparam int unsigned SW  = csa_pkg::SLICE_W[g];
    if (g == 0) begin : g_base
      csa_ripple #(.W(SW)) u_base (
        .a   (op_a[LSB +: SW]),
        .b   (op_b[LSB +: SW]),
        .cin (slice_c[g]),
        .s   (sum[LSB +: SW]),
        .co  (slice_c[g+1])
      );
    end else begin : g_sel
      csa_select_slice #(.W(SW)) u_sel (
        .a   (op_a[LSB +: SW]),
        .b   (op_b[LSB +: SW]),
        .cin (slice_c[g]),
        .s   (sum[LSB +: SW]),
        .co  (slice_c[g+1])
      );
    end
  end

  assign carry_out = slice_c[NG];

  always_comb begin
    if (!$isunknown({op_a, op_b, carry_in})) begin
      assert_full_sum_R1: assert ({carry_out, sum} ==
                                  ((DW+1)'(op_a) + (DW+1)'(op_b) + (DW+1)'(carry_in)))
        else $error("adder result wrong");
      if (&(op_a ^ op_b) && carry_in)
        assert_full_ripple_R7: assert (sum == '0 && carry_out)
          else $error("carry_in did not ripple through");
    end
  end
endmodule

// File: tb/tb_bec_sqrt_csa.sv
module tb_bec_sqrt_csa;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [15:0] op_a, op_b, sum;
  logic        carry_in, carry_out;

  bec_sqrt_csa dut (
    .op_a(op_a), .op_b(op_b), .carry_in(carry_in),
    .sum(sum), .carry_out(carry_out)
  );

  int n_tests = 0;
  int n_fail  = 0;

  typedef struct packed {
    logic [15:0] a;
    logic [15:0] b;
    logic        ci;
    logic [16:0] exp;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{16'h0000, 16'h0000, 1'b0, 17'h00000},  // R1 idle zero
    '{16'h0003, 16'h0000, 1'b1, 17'h00004},  // R2 carry_in into low slice
    '{16'h0002, 16'h0002, 1'b0, 17'h00004},  // R8 boundary above bit 1
    '{16'h0008, 16'h0008, 1'b0, 17'h00010},  // R8 boundary above bit 3
    '{16'h0040, 16'h0040, 1'b0, 17'h00080},  // R8 boundary above bit 6
    '{16'h0400, 16'h0400, 1'b0, 17'h00800},  // R8 boundary above bit 10
    '{16'hFFFF, 16'h0001, 1'b0, 17'h10000},  // R6 carry_out
    '{16'hFFFF, 16'h0000, 1'b1, 17'h10000},  // R7 full ripple
    '{16'hFFFF, 16'hFFFF, 1'b1, 17'h1FFFF},  // R1 max
    '{16'hFFFF, 16'hFFFF, 1'b0, 17'h1FFFE},  // R6 carry_out with sum
    '{16'h000F, 16'h0001, 1'b0, 17'h00010},  // R5 slice 1 wrap
    '{16'h007C, 16'h0004, 1'b0, 17'h00080},  // R5 wrap chain slices 1,2
    '{16'h1234, 16'h4321, 1'b0, 17'h05555},  // R4 no carries
    '{16'h5555, 16'h2AAA, 1'b0, 17'h07FFF},  // R4 no carries
    '{16'h7FFF, 16'h0001, 1'b0, 17'h08000},  // R5 wrap across slices
    '{16'h07FF, 16'h0001, 1'b0, 17'h00800}   // R5 wrap up to slice 4
  };

  task automatic apply_check(input logic [15:0] a, input logic [15:0] b,
                             input logic ci, input logic [16:0] exp,
                             input string req);
    @(negedge clk);
    op_a = a; op_b = b; carry_in = ci;
    #2;
    n_tests++;
    if ({carry_out, sum} !== exp) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h ci=%0d got %h expected %h",
               req, a, b, ci, {carry_out, sum}, exp);
    end
  endtask

  function automatic logic [16:0] ref_add(input logic [15:0] a,
                                          input logic [15:0] b, input logic ci);
    return 17'(a) + 17'(b) + 17'(ci);
  endfunction

  initial begin
    #1000000;
    n_tests++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    op_a = '0; op_b = '0; carry_in = 1'b0;
    // R1 quiescent output with zero inputs
    apply_check(16'h0000, 16'h0000, 1'b0, 17'h0, "R1");

    for (int i = 0; i < NV; i++)
      apply_check(VECS[i].a, VECS[i].b, VECS[i].ci, VECS[i].exp, "R1/R2/R4-R8 table");

    // R3: carry forced into each upper slice while its value sweeps all codes
    for (int g = 1; g < 5; g++) begin
      int lsb;
      int w;
      lsb = (g == 1) ? 2 : (g == 2) ? 4 : (g == 3) ? 7 : 11;
      w   = (g == 1) ? 2 : (g == 2) ? 3 : (g == 3) ? 4 : 5;
      for (int v = 0; v < (1 << w); v++) begin
        logic [15:0] a;
        logic [15:0] b;
        a = 16'((1 << lsb) - 1) | 16'(v << lsb);
        b = 16'h0001;
        apply_check(a, b, 1'b0, ref_add(a, b, 1'b0), "R3");
        // R4: same slice value with no incoming carry
        apply_check(16'(v << lsb), 16'h0000, 1'b0, 17'(v << lsb), "R4");
      end
    end

    // R7: carry_in through alternating propagate patterns
    apply_check(16'hAAAA, 16'h5555, 1'b1, 17'h10000, "R7");
    apply_check(16'h5555, 16'hAAAA, 1'b0, 17'h0FFFF, "R7");

    // R1: random operands
    for (int i = 0; i < 3000; i++) begin
      logic [15:0] a;
      logic [15:0] b;
      logic ci;
      a  = 16'($urandom);
      b  = 16'($urandom);
      ci = 1'($urandom);
      apply_check(a, b, ci, ref_add(a, b, ci), "R1");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule